// File: doc/BRIEF.md
# SPI Word Command Responder

This block is the slave end of a command/response link carried over a four-wire SPI bus. Every transfer is framed in 16-bit words. Frames run MSB first in SPI mode 0, and each frame opens when chip select goes low. The master first sends a region identifier and then a control word. Bit 15 of the control word sets the direction, and bits 14:0 give the number of payload words that follow. On a write, the payload words go into the selected region buffer at consecutive addresses. On a read, the region's words come back on MISO in the same word slots.

The responder always answers the first word of a frame with a fixed signature of 0x1122. Each write payload word is acknowledged with that same signature. The SPI pins are oversampled by the system clock, so SCK must stay well below the system clock rate. The region buffers live outside the block and are reached through a strobe-per-region memory port with a one-cycle read latency.

Top module: `spi_word_responder`

## Requirements
- R1: After reset, miso_o, err_o and every bit of mem_sel_o are 0.
- R2: In every frame, MISO carries 0x1122 during the first word (the region word), MSB first, changing after SCK falls and sampled by the master on SCK rise.
- R3: The second word is the control word: bit 15 = 1 selects write and 0 selects read, bits 14:0 give the payload word count. MISO is 0x0000 during this word.
- R4: A read of a defined region returns words at addresses 0, 1, 2, … of that region, one per payload slot, in order.
- R5: A write to a defined region stores payload word k at address k with exactly one strobe per word. MISO returns 0x1122 during every write payload word.
- R6: Payload addresses wrap modulo REGION_DEPTH (a power of two) when the count exceeds the depth.
- R7: A region identifier ≥ NUM_REGIONS sets err_o, which stays set until reset. Such a frame makes no memory access, and a read of it returns 0x0000 words.
- R8: Words sent after the payload count is used up return 0x0000 on MISO and cause no memory access.
- R9: Raising chip select in mid-word or mid-frame abandons the frame. The next frame starts again at the region word, with the bit counter cleared.
- R10: A count of zero causes no memory access, and every later word in that frame returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also used to oversample the SPI pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI clock, idles low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master, 0 while deselected |
| err_o | output | 1 | Sticky undefined-region flag |
| mem_sel_o | output | NUM_REGIONS | One-hot access strobe per region buffer |
| mem_we_o | output | 1 | Write enable qualifying mem_sel_o |
| mem_addr_o | output | $clog2(REGION_DEPTH) | Word address inside the region |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | NUM_REGIONS*16 | Read data per region, valid the cycle after the strobe |

## Verification
The bench builds the block with three regions of eight words each. With that depth, a ten-word write runs past the end of a region and lands on addresses 0 and 1, which makes the wrap visible. With three regions, identifier 3 is the first undefined one, so the sticky error path is reachable. SCK runs at twelve system clocks per period. That leaves room for the read prefetch between words, but the margin is small enough that a slower fetch path would show up as wrong MISO data.

// File: rtl/spi_wcr_pkg.sv
package spi_wcr_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] SIGNATURE = 16'h1122;
  typedef enum logic [1:0] {PH_REGION, PH_CTRL, PH_DATA, PH_DONE} phase_e;
endpackage

// File: rtl/spi_wcr_sync.sv
module spi_wcr_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_act_o,
  output logic cs_start_o,
  output logic mosi_o
);
  localparam int unsigned S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [S:0]   sck_p;
  logic [S:0]   cs_p;
  logic [S-1:0] mosi_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[S-1:0], sck_i};
      cs_p   <= {cs_p[S-1:0], cs_ni};
      mosi_p <= {mosi_p[S-2:0], mosi_i};
    end
  end

  assign sck_rise_o = sck_p[S-1] & ~sck_p[S];
  assign sck_fall_o = ~sck_p[S-1] & sck_p[S];
  assign cs_act_o   = ~cs_p[S-1];
  assign cs_start_o = ~cs_p[S-1] & cs_p[S];
  assign mosi_o     = mosi_p[S-1];
endmodule

// File: rtl/spi_wcr_shifter.sv
module spi_wcr_shifter
  import spi_wcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              cs_start_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  input  logic [WORD_W-1:0] start_word_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic              word_done_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic [WORD_W-1:0] tx_q_o
);
  localparam int unsigned CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     bit_cnt;
  logic [WORD_W-2:0] rx_sr;
  logic [WORD_W-1:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_q    <= '0;
    end else if (cs_start_i) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_q    <= start_word_i;
    end else if (!cs_act_i) begin
      bit_cnt <= '0;
    end else begin
      if (sck_rise_i) begin
        rx_sr   <= {rx_sr[WORD_W-3:0], mosi_i};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
      end
      // word boundary: next word enters on the fall after the last rise
      if (sck_fall_i) begin
        tx_q <= (bit_cnt == '0) ? load_word_i : {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign word_done_o = cs_act_i & ~cs_start_i & sck_rise_i & (bit_cnt == LAST);
  assign rx_word_o   = {rx_sr, mosi_i};
  assign tx_q_o      = tx_q;
endmodule

// File: rtl/spi_wcr_ctrl.sv
module spi_wcr_ctrl
  import spi_wcr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS  = 4,
  parameter int unsigned REGION_DEPTH = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cs_act_i,
  input  logic                          word_done_i,
  input  logic [WORD_W-1:0]             rx_word_i,
  input  logic [NUM_REGIONS*WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0]             load_word_o,
  output phase_e                        phase_o,
  output logic                          err_o,
  output logic [NUM_REGIONS-1:0]        mem_sel_o,
  output logic                          mem_we_o,
  output logic [$clog2(REGION_DEPTH)-1:0] mem_addr_o,
  output logic [WORD_W-1:0]             mem_wdata_o
);
  localparam int unsigned AW    = $clog2(REGION_DEPTH);
  localparam int unsigned RW    = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int unsigned LEN_W = WORD_W - 1;

  phase_e             phase_q;
  logic [RW-1:0]      reg_q;
  logic               reg_ok_q;
  logic               wr_q;
  logic [LEN_W-1:0]   left_q;
  logic [LEN_W-1:0]   idx_q;
  logic               err_q;
  logic [NUM_REGIONS-1:0] sel_q;
  logic               we_q;
  logic [AW-1:0]      addr_q;
  logic [WORD_W-1:0]  wdata_q;
  logic               pend_q;
  logic [WORD_W-1:0]  rd_q;

  logic               region_ok;
  logic [WORD_W-1:0]  rdata_sel;

  assign region_ok = rx_word_i < WORD_W'(NUM_REGIONS);
  assign rdata_sel = mem_rdata_i[reg_q*WORD_W +: WORD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_REGION;
      reg_q    <= '0;
      reg_ok_q <= 1'b0;
      wr_q     <= 1'b0;
      left_q   <= '0;
      idx_q    <= '0;
      err_q    <= 1'b0;
      sel_q    <= '0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      pend_q   <= 1'b0;
      rd_q     <= '0;
    end else begin
      sel_q  <= '0;
      we_q   <= 1'b0;
      pend_q <= (|sel_q) & ~we_q;
      if (pend_q) rd_q <= rdata_sel;

      if (!cs_act_i) begin
        phase_q <= PH_REGION;
      end else if (word_done_i) begin
        unique case (phase_q)
          PH_REGION: begin
            reg_q    <= rx_word_i[RW-1:0];
            reg_ok_q <= region_ok;
            if (!region_ok) err_q <= 1'b1;
            phase_q  <= PH_CTRL;
          end
          PH_CTRL: begin
            wr_q   <= rx_word_i[WORD_W-1];
            left_q <= rx_word_i[LEN_W-1:0];
            idx_q  <= '0;
            if (rx_word_i[LEN_W-1:0] == '0) begin
              phase_q <= PH_DONE;
            end else begin
              phase_q <= PH_DATA;
              if (!rx_word_i[WORD_W-1] && reg_ok_q) begin
                sel_q  <= NUM_REGIONS'(1) << reg_q;
                addr_q <= '0;
              end
            end
          end
          PH_DATA: begin
            if (wr_q && reg_ok_q) begin
              sel_q   <= NUM_REGIONS'(1) << reg_q;
              we_q    <= 1'b1;
              addr_q  <= idx_q[AW-1:0];
              wdata_q <= rx_word_i;
            end
            left_q <= left_q - 1'b1;
            idx_q  <= idx_q + 1'b1;
            if (left_q == LEN_W'(1)) begin
              phase_q <= PH_DONE;
            end else if (!wr_q && reg_ok_q) begin
              // prefetch the next read word
              sel_q  <= NUM_REGIONS'(1) << reg_q;
              addr_q <= AW'(idx_q + 1'b1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_REGION: load_word_o = SIGNATURE;
      PH_DATA:   load_word_o = wr_q ? SIGNATURE : (reg_ok_q ? rd_q : '0);
      default:   load_word_o = '0;
    endcase
  end

  assign phase_o     = phase_q;
  assign err_o       = err_q;
  assign mem_sel_o   = sel_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/spi_word_responder.sv
module spi_word_responder
  import spi_wcr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS  = 4,
  parameter int unsigned REGION_DEPTH = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            sck_i,
  input  logic                            cs_ni,
  input  logic                            mosi_i,
  output logic                            miso_o,
  output logic                            err_o,
  output logic [NUM_REGIONS-1:0]          mem_sel_o,
  output logic                            mem_we_o,
  output logic [$clog2(REGION_DEPTH)-1:0] mem_addr_o,
  output logic [15:0]                     mem_wdata_o,
  input  logic [NUM_REGIONS*16-1:0]       mem_rdata_i
);
  logic sck_rise, sck_fall, cs_act, cs_start, mosi_s, word_done;
  logic [WORD_W-1:0] rx_word, tx_q, load_word;
  phase_e phase;

  spi_wcr_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .cs_ni      (cs_ni),
    .mosi_i     (mosi_i),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .cs_act_o   (cs_act),
    .cs_start_o (cs_start),
    .mosi_o     (mosi_s)
  );

  spi_wcr_shifter i_shifter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_act_i     (cs_act),
    .cs_start_i   (cs_start),
    .sck_rise_i   (sck_rise),
    .sck_fall_i   (sck_fall),
    .mosi_i       (mosi_s),
    .start_word_i (SIGNATURE),
    .load_word_i  (load_word),
    .word_done_o  (word_done),
    .rx_word_o    (rx_word),
    .tx_q_o       (tx_q)
  );

  spi_wcr_ctrl #(
    .NUM_REGIONS  (NUM_REGIONS),
    .REGION_DEPTH (REGION_DEPTH)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (cs_act),
    .word_done_i (word_done),
    .rx_word_i   (rx_word),
    .mem_rdata_i (mem_rdata_i),
    .load_word_o (load_word),
    .phase_o     (phase),
    .err_o       (err_o),
    .mem_sel_o   (mem_sel_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign miso_o = cs_act & tx_q[WORD_W-1];
endmodule

// File: rtl/spi_word_responder_chk.sv
module spi_word_responder_chk
  import spi_wcr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_act,
  input logic                   cs_start,
  input logic                   word_done,
  input phase_e                 phase,
  input logic [WORD_W-1:0]      tx_q,
  input logic [NUM_REGIONS-1:0] mem_sel_o,
  input logic                   err_o
);
  assert_sig_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_start |=> tx_q == SIGNATURE);

  assert_sel_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_sel_o));

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_err_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(word_done));

  assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_DONE && $past(phase) == PH_DONE) |-> mem_sel_o == '0);

  assert_abort_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> phase == PH_REGION);
endmodule

bind spi_word_responder spi_word_responder_chk #(.NUM_REGIONS(NUM_REGIONS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_act    (cs_act),
  .cs_start  (cs_start),
  .word_done (word_done),
  .phase     (phase),
  .tx_q      (tx_q),
  .mem_sel_o (mem_sel_o),
  .err_o     (err_o)
);

// File: tb/test_spi_word_responder.sv
`timescale 1ns/1ps
module test_spi_word_responder;
  localparam int NREG  = 3;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int HP    = 6;
  localparam logic [15:0] SIG = 16'h1122;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, err;
  logic [NREG-1:0] sel;
  logic we;
  logic [AW-1:0] addr;
  logic [15:0] wdata;
  logic [NREG*16-1:0] rdata_flat;

  always #2.5 clk = ~clk;

  spi_word_responder #(.NUM_REGIONS(NREG), .REGION_DEPTH(DEPTH)) i_spi_word_responder (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .err_o(err), .mem_sel_o(sel), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata_flat)
  );

  // region buffer model, one-cycle read latency
  logic [15:0] mem [NREG][DEPTH];
  logic [15:0] rdata_r [NREG];
  int unsigned wr_cnt, sel_cnt;

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (sel[r]) begin
        if (we) mem[r][addr] <= wdata;
        else    rdata_r[r]   <= mem[r][addr];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt  <= 0;
      sel_cnt <= 0;
    end else begin
      if (|sel)       sel_cnt <= sel_cnt + 1;
      if (|sel && we) wr_cnt  <= wr_cnt + 1;
    end
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) rdata_flat[r*16 +: 16] = rdata_r[r];
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] got_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [15:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g === e, t, {16'h0, g}, {16'h0, e});
      end
    end
  end

  task automatic xfer(input logic [15:0] tx, input int nbits, input logic [15:0] exp, input string tag);
    logic [15:0] got = '0;
    if (nbits == 16) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    for (int i = 15; i > 15 - nbits; i--) begin
      mosi = tx[i];
      repeat (HP) @(negedge clk);
      got[i] = miso;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    if (nbits == 16) got_q.push_back(got);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic run_frame(input logic [15:0] region, input logic [15:0] ctrl,
                           input logic [15:0] tx[$], input logic [15:0] ex[$], input string tag);
    cs_begin();
    xfer(region, 16, SIG, "R2 signature word");
    xfer(ctrl, 16, 16'h0000, "R3 control slot");
    foreach (tx[i]) xfer(tx[i], 16, ex[i], tag);
    cs_end();
  endtask

  initial begin
    logic [15:0] tq[$];
    logic [15:0] eq[$];
    int unsigned w0, s0;
    repeat (4) @(negedge clk);
    chk(miso === 1'b0, "R1 miso after reset", {31'h0, miso}, 0);
    chk(err === 1'b0, "R1 err after reset", {31'h0, err}, 0);
    chk(sel === '0, "R1 sel after reset", {29'h0, sel}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 write three words to region 1
    w0 = wr_cnt;
    tq = {16'hA001, 16'hB002, 16'hC003}; eq = {SIG, SIG, SIG};
    run_frame(16'h0001, 16'h8003, tq, eq, "R5 write ack");
    chk(wr_cnt - w0 == 3, "R5 write strobes", wr_cnt - w0, 3);

    // R3 R4 read them back
    tq = {16'hFFFF, 16'h0000, 16'h5A5A}; eq = {16'hA001, 16'hB002, 16'hC003};
    run_frame(16'h0001, 16'h0003, tq, eq, "R4 read order");

    // R6 wrap: ten words into an eight-word region
    tq = {}; eq = {};
    for (int i = 0; i < 10; i++) begin tq.push_back(16'hD000 + 16'(i)); eq.push_back(SIG); end
    run_frame(16'h0002, 16'h800A, tq, eq, "R6 write ack");
    tq = {}; eq = {16'hD008, 16'hD009};
    for (int i = 0; i < 8; i++) tq.push_back(16'h0);
    for (int i = 2; i < 8; i++) eq.push_back(16'hD000 + 16'(i));
    run_frame(16'h0002, 16'h0008, tq, eq, "R6 wrapped read");

    // R8 words past the count
    tq = {16'h0, 16'h0, 16'h0, 16'h0}; eq = {16'hA001, 16'hB002, 16'h0000, 16'h0000};
    run_frame(16'h0001, 16'h0002, tq, eq, "R8 read overrun");
    w0 = wr_cnt;
    tq = {16'h7777, 16'h1234, 16'h4321}; eq = {SIG, 16'h0000, 16'h0000};
    run_frame(16'h0001, 16'h8001, tq, eq, "R8 write overrun");
    chk(wr_cnt - w0 == 1, "R8 single write strobe", wr_cnt - w0, 1);
    tq = {16'h0, 16'h0, 16'h0}; eq = {16'h7777, 16'hB002, 16'hC003};
    run_frame(16'h0001, 16'h0003, tq, eq, "R8 extra words not stored");

    // R10 zero count
    s0 = sel_cnt;
    tq = {16'hBEEF, 16'hCAFE}; eq = {16'h0000, 16'h0000};
    run_frame(16'h0001, 16'h8000, tq, eq, "R10 zero count");
    chk(sel_cnt == s0, "R10 no access", sel_cnt - s0, 0);

    // R7 undefined region
    chk(err === 1'b0, "R7 err clear before", {31'h0, err}, 0);
    s0 = sel_cnt;
    tq = {16'h1111, 16'h2222}; eq = {SIG, SIG};
    run_frame(16'h0003, 16'h8002, tq, eq, "R7 bad write ack");
    chk(sel_cnt == s0, "R7 no access on bad write", sel_cnt - s0, 0);
    chk(err === 1'b1, "R7 err set", {31'h0, err}, 1);
    tq = {16'h0, 16'h0}; eq = {16'h0000, 16'h0000};
    run_frame(16'h0003, 16'h0002, tq, eq, "R7 bad read zeros");
    chk(sel_cnt == s0, "R7 no access on bad read", sel_cnt - s0, 0);
    tq = {16'h0}; eq = {16'h7777};
    run_frame(16'h0001, 16'h0001, tq, eq, "R7 valid frame after error");
    chk(err === 1'b1, "R7 err sticky", {31'h0, err}, 1);

    // R9 abort mid control word, then mid region word
    s0 = sel_cnt;
    cs_begin();
    xfer(16'h0001, 16, SIG, "R9 signature before abort");
    xfer(16'h8002, 8, 16'h0, "R9 partial");
    cs_end();
    chk(sel_cnt == s0, "R9 no access after abort", sel_cnt - s0, 0);
    cs_begin();
    xfer(16'h0001, 5, 16'h0, "R9 partial region");
    cs_end();
    tq = {16'h0}; eq = {16'h7777};
    run_frame(16'h0001, 16'h0001, tq, eq, "R9 frame after abort");
    chk(sel_cnt - s0 == 1, "R9 one read after abort", sel_cnt - s0, 1);
    chk(miso === 1'b0, "R1 miso idle when deselected", {31'h0, miso}, 0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule